// File: doc/BRIEF.md
# Packet Stream Receive Sink

This block terminates a 128-bit packetized receive stream on the application side. The upstream source marks each beat with qualifier bits for first beat, last beat, half-empty last beat and fault. The sink returns a ready hint to that source. Ready is only advisory: the source can take several cycles to react to it, so the sink must keep capturing beats after ready has fallen. The sink places every beat in a small elastic queue and presents it again on a downstream port that follows a plain valid/ready handshake with no latency.

On the way through, the sink repairs packet framing so that the downstream consumer always sees well-formed packets. A fault seen on any beat is carried as a sticky flag up to the last beat of its packet. A packet that is interrupted by a new first beat is closed early and tagged. A beat that arrives with no packet open is promoted to a first beat and tagged. Idle cycles inside a packet are allowed and do not affect framing.

Top module: `pkt_rx_sink`

## Requirements
- R1: Every beat the source presents with `up_valid` high is captured and delivered downstream exactly once, in arrival order, with its data unchanged, whatever the level of `up_ready` was in that cycle.
- R2: While `rst` is high, `up_ready` and `dn_valid` are low. `up_ready` also stays low for the first clock cycle after `rst` is released.
- R3: `up_ready` is high only while the queue has at least `SRC_LAT`+3 free entries. If the downstream side stalls, `up_ready` falls and stays low, and all beats still in flight are absorbed. Once the queue has drained, `up_ready` returns high.
- R4: Cycles with `up_valid` low between the first and last beat of a packet do not change the first-beat or last-beat markings seen downstream.
- R5: `dn_empty` equals the `up_empty` value of the corresponding beat when that beat is a last beat (`up_eop`=1), and is 0 on every other beat. On the 128-bit bus, a 1 means only the lower 64 data bits are meaningful.
- R6: `dn_err` on a delivered beat is 1 if that beat or any earlier beat of the same packet arrived with `up_err` high. The flag restarts at each new packet. A fault beat that also ends the packet early closes the packet normally.
- R7: When a beat with `up_sop`=1 arrives while a packet is still open, the previous beat of the open packet is delivered with `dn_eop`=1, `dn_err`=1 and `dn_empty`=0. The new beat then starts a fresh packet.
- R8: A beat without `up_sop` that arrives when no packet is open is delivered with `dn_sop`=1 and `dn_err`=1, and it opens a packet.
- R9: A downstream beat transfers only in a cycle where both `dn_valid` and `dn_ready` are high. While a beat is stalled, `dn_valid` and all downstream fields stay constant.
- R10: Downstream, `dn_sop` is set on a transferred beat exactly when no packet is open, so every delivered packet starts with a first beat and ends with a last beat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_valid | input | 1 | Upstream beat present |
| up_data | input | DATA_W | Upstream beat data |
| up_sop | input | 1 | Upstream first beat of a packet |
| up_eop | input | 1 | Upstream last beat of a packet |
| up_empty | input | 1 | Last beat uses only the lower half of the bus |
| up_err | input | 1 | Upstream fault on this beat |
| up_ready | output | 1 | Throttle hint to the source |
| dn_valid | output | 1 | Downstream beat available |
| dn_data | output | DATA_W | Downstream beat data |
| dn_sop | output | 1 | Downstream first beat |
| dn_eop | output | 1 | Downstream last beat |
| dn_empty | output | 1 | Downstream last beat is half-empty |
| dn_err | output | 1 | Downstream packet fault flag |
| dn_ready | input | 1 | Downstream consumer accepts the beat |

## Verification
The bench builds the sink with a 128-bit bus, an 8-entry queue and a source lag of 3. With these values the throttle threshold is only two entries of fill, so `up_ready` toggles often under random downstream back-pressure, and the source model's full three-cycle reaction lag pushes the queue to the edge of its absorption margin. The 128-bit width selects the variant that honours the half-empty flag, so R5 is checked on both last and non-last beats. Random phases sweep the source lag from 0 to 3 while also injecting faults, interrupted packets and orphan beats.

// File: rtl/pkt_rx_pkg.sv
package pkt_rx_pkg;

   // Qualifier bits stored alongside each buffered beat.
   typedef struct packed {
      logic sop;
      logic eop;
      logic empty;
      logic err;
   } beat_tag_t;

   localparam int TAG_W = $bits(beat_tag_t);

   // Bus width from which the half-empty qualifier carries meaning.
   localparam int HALF_FLAG_MIN_W = 128;

   // Fill level above which the source must be throttled.
   function automatic int fill_limit(input int depth, input int src_lat);
      return depth - src_lat - 3;
   endfunction

endpackage

// File: rtl/pkt_rx_framer.sv
module pkt_rx_framer
   import pkt_rx_pkg::*;
#(
   parameter int DATA_W = 128
)
(
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_sop,
   input  logic              in_eop,
   input  logic              in_empty,
   input  logic              in_err,
   output logic              push,
   output logic [DATA_W-1:0] push_data,
   output beat_tag_t         push_tag
);

   logic              stage_vld_q;
   logic [DATA_W-1:0] stage_data_q;
   beat_tag_t         stage_tag_q;
   beat_tag_t         next_tag;
   logic              empty_ok;
   logic              pkt_open;
   logic              orphan;
   logic              cut_short;

   // Variant: the half-empty flag only means something on wide buses.
   generate
      if (DATA_W >= HALF_FLAG_MIN_W) begin : g_half_flag
         assign empty_ok = in_empty;
      end else begin : g_no_half_flag
         logic unused_empty;
         assign unused_empty = in_empty;
         assign empty_ok     = 1'b0;
      end
   endgenerate

   // A non-last beat waits in the stage until its successor shows up.
   // That is how a mid-packet first beat can still rewrite it.
   assign pkt_open  = stage_vld_q && !stage_tag_q.eop;
   assign orphan    = in_valid && !in_sop && !pkt_open;
   assign cut_short = in_valid && in_sop && pkt_open;

   always_comb begin
      next_tag.sop   = in_sop | orphan;
      next_tag.eop   = in_eop;
      next_tag.empty = in_eop & empty_ok;
      next_tag.err   = in_err | orphan | (pkt_open & ~in_sop & stage_tag_q.err);
   end

   assign push      = stage_vld_q && (in_valid || stage_tag_q.eop);
   assign push_data = stage_data_q;

   always_comb begin
      push_tag = stage_tag_q;
      if (cut_short) begin
         push_tag.eop   = 1'b1;
         push_tag.err   = 1'b1;
         push_tag.empty = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         stage_vld_q  <= 1'b0;
         stage_tag_q  <= '0;
         stage_data_q <= '0;
      end else if (in_valid) begin
         stage_vld_q  <= 1'b1;
         stage_data_q <= in_data;
         stage_tag_q  <= next_tag;
      end else if (push) begin
         stage_vld_q  <= 1'b0;
      end
   end

endmodule

// File: rtl/pkt_rx_fifo.sv
module pkt_rx_fifo
#(
   parameter  int WIDTH = 132,
   parameter  int DEPTH = 8,
   localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW    = $clog2(DEPTH + 1)
)
(
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             rd_en,
   output logic             rd_valid,
   output logic [WIDTH-1:0] rd_data,
   output logic [CW-1:0]    count
);

   logic [WIDTH-1:0] mem_q [DEPTH];
   logic [AW-1:0]    wr_ptr_q;
   logic [AW-1:0]    rd_ptr_q;
   logic [CW-1:0]    count_q;
   logic             full;
   logic             wr_ok;
   logic             rd_ok;

   function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
      return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
   endfunction

   assign full     = (count_q == CW'(DEPTH));
   assign rd_valid = (count_q != '0);
   assign rd_ok    = rd_en && rd_valid;
   assign wr_ok    = wr_en && (!full || rd_ok);
   assign rd_data  = mem_q[rd_ptr_q];
   assign count    = count_q;

   always_ff @(posedge clk) begin
      if (wr_ok) begin
         mem_q[wr_ptr_q] <= wr_data;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         count_q  <= '0;
      end else begin
         if (wr_ok) wr_ptr_q <= bump(wr_ptr_q);
         if (rd_ok) rd_ptr_q <= bump(rd_ptr_q);
         unique case ({wr_ok, rd_ok})
            2'b10:   count_q <= count_q + CW'(1);
            2'b01:   count_q <= count_q - CW'(1);
            default: count_q <= count_q;
         endcase
      end
   end

endmodule

// File: rtl/pkt_rx_throttle.sv
module pkt_rx_throttle
   import pkt_rx_pkg::*;
#(
   parameter  int DEPTH   = 8,
   parameter  int SRC_LAT = 3,
   localparam int CW      = $clog2(DEPTH + 1)
)
(
   input  logic          clk,
   input  logic          rst,
   input  logic [CW-1:0] fill,
   input  logic          inc,
   input  logic          dec,
   output logic          ready
);

   localparam int LIMIT = fill_limit(DEPTH, SRC_LAT);

   logic [CW:0] fill_next;
   logic        hold_q;
   logic        ready_q;

   // Look one edge ahead so the hint is registered without losing a cycle.
   always_comb begin
      fill_next = {1'b0, fill} + {{CW{1'b0}}, inc} - {{CW{1'b0}}, dec};
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         hold_q  <= 1'b1;
         ready_q <= 1'b0;
      end else begin
         hold_q  <= 1'b0;
         ready_q <= !hold_q && (fill_next <= (CW + 1)'(LIMIT));
      end
   end

   assign ready = ready_q;

endmodule

// File: rtl/pkt_rx_sink.sv
module pkt_rx_sink
   import pkt_rx_pkg::*;
#(
   parameter int DATA_W  = 128,
   parameter int DEPTH   = 8,
   parameter int SRC_LAT = 3
)
(
   input  logic              clk,
   input  logic              rst,
   input  logic              up_valid,
   input  logic [DATA_W-1:0] up_data,
   input  logic              up_sop,
   input  logic              up_eop,
   input  logic              up_empty,
   input  logic              up_err,
   output logic              up_ready,
   output logic              dn_valid,
   output logic [DATA_W-1:0] dn_data,
   output logic              dn_sop,
   output logic              dn_eop,
   output logic              dn_empty,
   output logic              dn_err,
   input  logic              dn_ready
);

   localparam int WORD_W = DATA_W + TAG_W;
   localparam int CW     = $clog2(DEPTH + 1);

   generate
      if (DEPTH < SRC_LAT + 4) begin : g_bad_depth
         $error("pkt_rx_sink: DEPTH must be at least SRC_LAT + 4");
      end
      if (SRC_LAT < 0) begin : g_bad_lat
         $error("pkt_rx_sink: SRC_LAT must not be negative");
      end
      if (DATA_W < 8) begin : g_bad_width
         $error("pkt_rx_sink: DATA_W must be at least 8");
      end
   endgenerate

   logic              push;
   logic [DATA_W-1:0] push_data;
   beat_tag_t         push_tag;
   logic              fifo_rd;
   logic [CW-1:0]     fifo_cnt;
   logic [WORD_W-1:0] rd_word;
   beat_tag_t         rd_tag;

   pkt_rx_framer #(.DATA_W(DATA_W)) u_framer (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (up_valid),
      .in_data   (up_data),
      .in_sop    (up_sop),
      .in_eop    (up_eop),
      .in_empty  (up_empty),
      .in_err    (up_err),
      .push      (push),
      .push_data (push_data),
      .push_tag  (push_tag)
   );

   pkt_rx_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_fifo (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (push),
      .wr_data  ({push_tag, push_data}),
      .rd_en    (dn_ready),
      .rd_valid (dn_valid),
      .rd_data  (rd_word),
      .count    (fifo_cnt)
   );

   pkt_rx_throttle #(.DEPTH(DEPTH), .SRC_LAT(SRC_LAT)) u_throttle (
      .clk   (clk),
      .rst   (rst),
      .fill  (fifo_cnt),
      .inc   (push),
      .dec   (fifo_rd),
      .ready (up_ready)
   );

   assign fifo_rd  = dn_valid && dn_ready;
   assign rd_tag   = beat_tag_t'(rd_word[WORD_W-1:DATA_W]);
   assign dn_data  = rd_word[DATA_W-1:0];
   assign dn_sop   = rd_tag.sop;
   assign dn_eop   = rd_tag.eop;
   assign dn_empty = rd_tag.empty;
   assign dn_err   = rd_tag.err;

endmodule

// File: rtl/pkt_rx_sink_chk.sv
module pkt_rx_sink_chk
#(
   parameter  int DATA_W  = 128,
   parameter  int DEPTH   = 8,
   parameter  int SRC_LAT = 3,
   localparam int CW      = $clog2(DEPTH + 1)
)
(
   input logic              clk,
   input logic              rst,
   input logic              up_ready,
   input logic              dn_valid,
   input logic [DATA_W-1:0] dn_data,
   input logic              dn_sop,
   input logic              dn_eop,
   input logic              dn_ready,
   input logic              push,
   input logic              fifo_rd,
   input logic [CW-1:0]     fifo_cnt
);

   logic open_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         open_q <= 1'b0;
      end else if (dn_valid && dn_ready) begin
         open_q <= !dn_eop;
      end
   end

   assert_ready_low_after_reset_R2: assert property (
      @(posedge clk) ($past(rst) && !rst) |=> !up_ready);

   assert_no_overflow_R1: assert property (
      @(posedge clk) disable iff (rst)
      (push && !fifo_rd) |-> (fifo_cnt < CW'(DEPTH)));

   assert_ready_margin_R3: assert property (
      @(posedge clk) disable iff (rst)
      up_ready |-> (fifo_cnt <= CW'(DEPTH - SRC_LAT - 3)));

   assert_hold_stalled_R9: assert property (
      @(posedge clk) disable iff (rst)
      (dn_valid && !dn_ready) |=>
         (dn_valid && $stable(dn_data) && $stable(dn_sop) && $stable(dn_eop)));

   assert_out_framing_R10: assert property (
      @(posedge clk) disable iff (rst)
      (dn_valid && dn_ready) |-> (dn_sop == !open_q));

endmodule

bind pkt_rx_sink pkt_rx_sink_chk #(
   .DATA_W  (DATA_W),
   .DEPTH   (DEPTH),
   .SRC_LAT (SRC_LAT)
) u_chk (.*);

// File: tb/pkt_rx_sink_tb.sv
`timescale 1ns/1ps
module pkt_rx_sink_tb;

   localparam int DATA_W  = 128;
   localparam int DEPTH   = 8;
   localparam int SRC_LAT = 3;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #2 clk = ~clk;

   logic              up_valid = 1'b0;
   logic [DATA_W-1:0] up_data  = '0;
   logic              up_sop   = 1'b0;
   logic              up_eop   = 1'b0;
   logic              up_empty = 1'b0;
   logic              up_err   = 1'b0;
   logic              up_ready;
   logic              dn_valid;
   logic [DATA_W-1:0] dn_data;
   logic              dn_sop, dn_eop, dn_empty, dn_err;
   logic              dn_ready = 1'b0;

   pkt_rx_sink #(.DATA_W(DATA_W), .DEPTH(DEPTH), .SRC_LAT(SRC_LAT)) u_dut (
      .clk(clk), .rst(rst),
      .up_valid(up_valid), .up_data(up_data), .up_sop(up_sop), .up_eop(up_eop),
      .up_empty(up_empty), .up_err(up_err), .up_ready(up_ready),
      .dn_valid(dn_valid), .dn_data(dn_data), .dn_sop(dn_sop), .dn_eop(dn_eop),
      .dn_empty(dn_empty), .dn_err(dn_err), .dn_ready(dn_ready)
   );

   typedef struct {
      logic [DATA_W-1:0] d;
      logic              sop, eop, empty, err;
      string             tag;
   } exp_t;

   exp_t exp_q[$];
   int   n_checks = 0;
   int   n_errors = 0;
   bit   done = 0;
   int   lag = 0;
   int   rdy_pct = 100;
   logic [3:0] hist = '0;
   bit   model_open = 0;
   bit   stall_prev = 0;
   logic [DATA_W-1:0] stall_data;
   logic stall_sop, stall_eop;

   // random source state
   bit   src_open = 0, pend = 0, gap_next = 0;
   int   src_left = 0, send_pct = 100, err_pct = 0, fr_pct = 0, orph_pct = 0;
   logic [DATA_W-1:0] cd;
   logic cs, ce, cm, cr;

   function automatic logic [DATA_W-1:0] rnd_data();
      return {$urandom(), $urandom(), $urandom(), $urandom()};
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] expv);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
      end
   endtask

   // Expected-stream model built from the requirements.
   task automatic model_take(input logic [DATA_W-1:0] d, input logic s, e, m, r);
      exp_t b;
      exp_t t;
      bit was_open;
      bit orphan;
      was_open = model_open;
      orphan   = !s && !was_open;
      if (s && was_open && exp_q.size() > 0) begin   // R7 closure
         t = exp_q[exp_q.size()-1];
         t.eop = 1'b1; t.err = 1'b1; t.empty = 1'b0; t.tag = "R7";
         exp_q[exp_q.size()-1] = t;
      end
      b.d     = d;
      b.sop   = s | orphan;
      b.eop   = e;
      b.empty = e & m;
      b.err   = r | orphan;
      if (was_open && !s && exp_q.size() > 0 && exp_q[exp_q.size()-1].err) b.err = 1'b1;
      b.tag   = orphan ? "R8" : "R6";
      exp_q.push_back(b);
      model_open = !e;
   endtask

   task automatic cycle(input logic want, input logic [DATA_W-1:0] d,
                        input logic s, e, m, r, output bit sent);
      exp_t x;
      @(negedge clk);
      hist = {hist[2:0], up_ready};
      sent = want && hist[lag];
      up_valid = sent;
      up_data  = d;
      up_sop   = s;
      up_eop   = e;
      up_empty = m;
      up_err   = r;
      dn_ready = ($urandom_range(99) < rdy_pct);
      #1;
      if (stall_prev)
         check(dn_valid && dn_data == stall_data && dn_sop == stall_sop && dn_eop == stall_eop,
               "R9", "stalled beat changed", dn_data, stall_data);
      if (dn_valid && dn_ready) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R1", "unexpected beat", dn_data, '0);
         end else begin
            x = exp_q.pop_front();
            check(dn_data == x.d, "R1", "data/order", dn_data, x.d);
            check(dn_sop == x.sop && dn_eop == x.eop, (x.tag == "R6") ? "R4" : x.tag,
                  "sop/eop", {dn_sop, dn_eop}, {x.sop, x.eop});
            check(dn_empty == x.empty, "R5", "empty", dn_empty, x.empty);
            check(dn_err == x.err, x.tag, "err", dn_err, x.err);
         end
      end
      stall_prev = dn_valid && !dn_ready;
      stall_data = dn_data;
      stall_sop  = dn_sop;
      stall_eop  = dn_eop;
      if (sent) model_take(d, s, e, m, r);
   endtask

   task automatic send(input logic s, e, m, r);
      bit sent;
      logic [DATA_W-1:0] d;
      d = rnd_data();
      sent = 0;
      while (!sent) cycle(1'b1, d, s, e, m, r, sent);
   endtask

   task automatic idle(input int n);
      bit sent;
      for (int i = 0; i < n; i++) cycle(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0, sent);
   endtask

   task automatic rand_cycle();
      bit sent;
      bit want;
      if (!pend) begin
         cs = !src_open;
         if (src_open && $urandom_range(99) < fr_pct) cs = 1'b1;
         if (!src_open && $urandom_range(99) < orph_pct) cs = 1'b0;
         if (cs || !src_open) src_left = $urandom_range(5, 1);
         ce = (src_left == 1);
         cr = ($urandom_range(99) < err_pct);
         if (cr) ce = 1'b1;
         cm = 1'($urandom_range(1));
         cd = rnd_data();
         src_left--;
         src_open = !ce;
         pend = 1;
      end
      want = !gap_next && ($urandom_range(99) < send_pct);
      cycle(want, cd, cs, ce, cm, cr, sent);
      if (!sent) gap_next = 0;
      else begin
         pend = 0;
         if (cr) gap_next = 1;
      end
   endtask

   task automatic report();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      // R2: reset state
      repeat (5) @(negedge clk);
      #1;
      check(up_ready == 1'b0, "R2", "ready in reset", up_ready, 0);
      check(dn_valid == 1'b0, "R2", "valid in reset", dn_valid, 0);
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      #1;
      check(up_ready == 1'b0, "R2", "ready first cycle after reset", up_ready, 0);
      @(negedge clk);
      #1;
      check(up_ready == 1'b1, "R3", "ready with empty queue", up_ready, 1);

      // Directed corner cases, lag 0, downstream always ready
      lag = 0; rdy_pct = 100;
      send(1, 1, 1, 0);                       // R5 single half-empty beat
      send(1, 0, 1, 0); idle(2);              // R4 gaps, R5 empty on non-eop ignored
      send(0, 0, 1, 0); idle(1);
      send(0, 1, 0, 0);
      send(1, 0, 0, 0); send(0, 1, 0, 1);     // R6 fault ends packet early
      idle(1);
      send(1, 0, 0, 0); send(0, 1, 0, 0);     // R6 flag restarts
      send(1, 0, 0, 1); send(0, 0, 0, 0); send(0, 1, 1, 0);  // R6 sticky
      send(1, 0, 0, 0); send(0, 0, 0, 0);     // R7 interrupted packet
      send(1, 0, 0, 0); send(0, 1, 0, 0);
      send(0, 0, 0, 0); send(0, 1, 0, 0);     // R8 orphan opens packet
      idle(12);
      check(exp_q.size() == 0, "R1", "directed drain", exp_q.size(), 0);

      // R3 stall with full source lag
      lag = 3; rdy_pct = 0;
      for (int i = 0; i < 40; i++) begin
         bit sent;
         cycle(1'b1, rnd_data(), 1'b1, 1'b1, 1'b0, 1'b0, sent);
      end
      idle(5);
      check(up_ready == 1'b0, "R3", "ready while stalled", up_ready, 0);
      check(exp_q.size() <= DEPTH + 1, "R3", "beats absorbed", exp_q.size(), DEPTH + 1);
      rdy_pct = 100;
      idle(30);
      check(exp_q.size() == 0, "R1", "stall drain", exp_q.size(), 0);
      check(up_ready == 1'b1, "R3", "ready after drain", up_ready, 1);

      // Random phases sweeping source lag and back-pressure
      err_pct = 4; fr_pct = 3; orph_pct = 3;
      for (int p = 0; p < 4; p++) begin
         lag = p;
         rdy_pct = 100 - p * 25;
         send_pct = 60 + p * 10;
         for (int i = 0; i < 4000; i++) rand_cycle();
      end
      lag = 0; rdy_pct = 100;
      send(1, 1, 0, 0);                       // closes any open packet
      idle(40);
      check(exp_q.size() == 0, "R1", "final drain", exp_q.size(), 0);

      done = 1;
      report();
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         report();
         $finish;
      end
   end

endmodule